// File: doc/BRIEF.md
# Boost Switch Cycle Gate Controller

This block decides, one switching period at a time, whether the external boost power switch is driven on and for how long. An oscillator elsewhere supplies a one-clock pulse at the start of each period. The block turns the gate request on at that pulse. It then ends the on time on the first of these events:

- the peak-current comparator trips;
- the selected over-current comparator trips;
- the duty-cycle ceiling is reached.

A short blanking window at the start of each on time keeps the peak-current comparator from cutting the pulse too early.

When the regulation loop reports that even the shortest pulse delivers too much energy, the block skips whole periods and keeps the switch off. In normal PWM operation the over-current decision comes from the higher-threshold comparator. In light-load PFM operation it comes from the lower-threshold comparator. All timing is counted in system-clock cycles. The period length, the duty limit in percent, the blanking length and the number of periods skipped are parameters.

Top module: `boost_gate_ctrl`

## Requirements
- R1: When `enable` is high, the gate is off and no skip is pending, a `cycleStart` pulse drives `gateOn` high from the next clock. A `cycleStart` that arrives while the gate is on is ignored.
- R2: A high `rampTrip` during the on time turns `gateOn` off at the next clock, once the blanking window has passed.
- R3: Whatever `rampTrip` does, an on time lasts at least MIN_ON_CYC cycles unless over-current or `enable` ends it. The default is 3.
- R4: An on time never lasts more than MAX_ON_CYC = PERIOD_CYC*DUTY_PCT/100 cycles. With the defaults this is 50*94/100 = 47.
- R5: A high selected over-current flag while the gate is on turns `gateOn` off at the next clock. This takes priority over blanking, and the gate stays off until the next `cycleStart`.
- R6: With `lightLoad`=0 the over-current flag in use is `ocpHiTrip`. With `lightLoad`=1 it is `ocpLoTrip`. The flag not in use has no effect.
- R7: A `skipReq` that is high together with `cycleStart` suppresses the pulse in that period and in the next SKIP_PERIODS-1 periods. The default is 3 periods in all. The first period after that switches again.
- R8: With `enable` low, `gateOn` is low at the next clock, `cycleStart` is ignored, and the on-time count and any pending skip are cleared.
- R9: While `rst_n` is low and after it is released, `gateOn` is low until a `cycleStart` is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Global run enable |
| cycleStart | input | 1 | One-clock pulse at the start of each switching period |
| rampTrip | input | 1 | Inductor current ramp has reached the error-amplifier level |
| ocpHiTrip | input | 1 | Over-current flag, higher threshold (normal mode) |
| ocpLoTrip | input | 1 | Over-current flag, lower threshold (light-load mode) |
| skipReq | input | 1 | Regulation exceeded even at minimum pulse; request period skipping |
| lightLoad | input | 1 | Mode select: 0 normal PWM, 1 light-load PFM |
| gateOn | output | 1 | Gate-drive request for the boost switch |

## Verification
The bound checker watches the following properties on every clock:
- the gate drops after `enable` falls;
- the gate rises only after an accepted cycle start;
- the gate falls after a trip of the selected over-current flag;
- the on time never exceeds the duty ceiling;
- the on time never falls below the blanking length unless over-current or disable ends it.

Only the bench scenarios show the exact pulse width for each trip time, the choice between the two over-current flags by mode, the count of whole skipped periods, and the clearing of a pending skip by disable.

// File: rtl/bgc_pkg.sv
package bgc_pkg;

  // Strobes issued by the control FSM to the counter datapath
  typedef struct packed {
    logic clear;     // drop all period state
    logic startOn;   // a new on time begins
    logic countOn;   // on time continues this cycle
    logic skipLoad;  // arm the skip counter
    logic skipDec;   // one skipped period consumed
  } bgcStrobe_t;

endpackage

// File: rtl/bgc_datapath.sv
module bgc_datapath
  import bgc_pkg::*;
#(
  parameter int MIN_ON_CYC   = 3,
  parameter int MAX_ON_CYC   = 47,
  parameter int SKIP_PERIODS = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  bgcStrobe_t strobe,
  output logic       minDone,
  output logic       maxDone,
  output logic       skipping
);

  localparam int ON_W   = $clog2(MAX_ON_CYC + 2);
  localparam int SKIP_W = $clog2(SKIP_PERIODS + 1);
  localparam logic [ON_W-1:0]   MIN_LIM  = ON_W'(MIN_ON_CYC);
  localparam logic [ON_W-1:0]   MAX_LIM  = ON_W'(MAX_ON_CYC);
  localparam logic [SKIP_W-1:0] SKIP_RLD = SKIP_W'(SKIP_PERIODS - 1);

  logic [ON_W-1:0]   onCnt;
  logic [SKIP_W-1:0] skipLeft;

  // onCnt holds the number of cycles the gate has been high, this one included
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      onCnt <= '0;
    end else if (strobe.clear) begin
      onCnt <= '0;
    end else if (strobe.startOn) begin
      onCnt <= ON_W'(1);
    end else if (strobe.countOn) begin
      onCnt <= onCnt + ON_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      skipLeft <= '0;
    end else if (strobe.clear) begin
      skipLeft <= '0;
    end else if (strobe.skipLoad) begin
      skipLeft <= SKIP_RLD;
    end else if (strobe.skipDec) begin
      skipLeft <= skipLeft - SKIP_W'(1);
    end
  end

  assign minDone  = (onCnt >= MIN_LIM);
  assign maxDone  = (onCnt >= MAX_LIM);
  assign skipping = (skipLeft != '0);

endmodule

// File: rtl/bgc_control.sv
module bgc_control
  import bgc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enable,
  input  logic       cycleStart,
  input  logic       rampTrip,
  input  logic       ocpHiTrip,
  input  logic       ocpLoTrip,
  input  logic       skipReq,
  input  logic       lightLoad,
  input  logic       minDone,
  input  logic       maxDone,
  input  logic       skipping,
  output bgcStrobe_t strobe,
  output logic       gateOn
);

  logic gateQ;
  logic ocpSel;
  logic turnOff;
  logic startSeen;
  logic startNow;

  always_comb begin
    ocpSel    = lightLoad ? ocpLoTrip : ocpHiTrip;
    // over-current is checked before the blanking qualifier
    turnOff   = gateQ && (ocpSel || (rampTrip && minDone) || maxDone);
    startSeen = enable && !gateQ && cycleStart;
    startNow  = startSeen && !skipping && !skipReq;

    strobe          = '0;
    strobe.clear    = !enable;
    strobe.startOn  = startNow;
    strobe.countOn  = enable && gateQ && !turnOff;
    strobe.skipLoad = startSeen && !skipping && skipReq;
    strobe.skipDec  = startSeen && skipping;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gateQ <= 1'b0;
    end else if (!enable) begin
      gateQ <= 1'b0;
    end else if (startNow) begin
      gateQ <= 1'b1;
    end else if (turnOff) begin
      gateQ <= 1'b0;
    end
  end

  assign gateOn = gateQ;

endmodule

// File: rtl/boost_gate_ctrl.sv
module boost_gate_ctrl
  import bgc_pkg::*;
#(
  parameter int PERIOD_CYC   = 50,
  parameter int DUTY_PCT     = 94,
  parameter int MIN_ON_CYC   = 3,
  parameter int SKIP_PERIODS = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic cycleStart,
  input  logic rampTrip,
  input  logic ocpHiTrip,
  input  logic ocpLoTrip,
  input  logic skipReq,
  input  logic lightLoad,
  output logic gateOn
);

  localparam int MAX_ON_CYC = (PERIOD_CYC * DUTY_PCT) / 100;

  bgcStrobe_t strobe;
  logic minDone;
  logic maxDone;
  logic skipping;

  bgc_control u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (enable),
    .cycleStart (cycleStart),
    .rampTrip   (rampTrip),
    .ocpHiTrip  (ocpHiTrip),
    .ocpLoTrip  (ocpLoTrip),
    .skipReq    (skipReq),
    .lightLoad  (lightLoad),
    .minDone    (minDone),
    .maxDone    (maxDone),
    .skipping   (skipping),
    .strobe     (strobe),
    .gateOn     (gateOn)
  );

  bgc_datapath #(
    .MIN_ON_CYC   (MIN_ON_CYC),
    .MAX_ON_CYC   (MAX_ON_CYC),
    .SKIP_PERIODS (SKIP_PERIODS)
  ) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobe   (strobe),
    .minDone  (minDone),
    .maxDone  (maxDone),
    .skipping (skipping)
  );

endmodule

// File: rtl/bgc_checker.sv
module bgc_checker #(
  parameter int MIN_ON_CYC = 3,
  parameter int MAX_ON_CYC = 47
) (
  input logic clk,
  input logic rst_n,
  input logic enable,
  input logic cycleStart,
  input logic ocpHiTrip,
  input logic ocpLoTrip,
  input logic lightLoad,
  input logic gateOn
);

  localparam int RUN_W = $clog2(MAX_ON_CYC + 2);

  logic [RUN_W-1:0] runLen;  // high cycles seen before the current one
  logic ocpSel;

  assign ocpSel = lightLoad ? ocpLoTrip : ocpHiTrip;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      runLen <= '0;
    end else if (!gateOn) begin
      runLen <= '0;
    end else if (runLen <= RUN_W'(MAX_ON_CYC)) begin
      runLen <= runLen + RUN_W'(1);
    end
  end

  assert_disable_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !gateOn);

  assert_rise_on_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gateOn) |-> ($past(cycleStart) && $past(enable)));

  assert_ocp_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (gateOn && ocpSel) |=> !gateOn);

  assert_max_on_R4: assert property (@(posedge clk) disable iff (!rst_n)
    gateOn |-> (int'(runLen) < MAX_ON_CYC));

  assert_min_on_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (gateOn && enable && !ocpSel && (int'(runLen) + 1 < MIN_ON_CYC)) |=> gateOn);

endmodule

bind boost_gate_ctrl bgc_checker #(
  .MIN_ON_CYC (MIN_ON_CYC),
  .MAX_ON_CYC (MAX_ON_CYC)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .enable     (enable),
  .cycleStart (cycleStart),
  .ocpHiTrip  (ocpHiTrip),
  .ocpLoTrip  (ocpLoTrip),
  .lightLoad  (lightLoad),
  .gateOn     (gateOn)
);

// File: tb/boost_gate_ctrl_tb.sv
module boost_gate_ctrl_tb;

  localparam int PERIOD = 50;
  localparam int DUTY   = 94;
  localparam int MINON  = 3;
  localparam int SKIPN  = 3;
  localparam int MAXON  = (PERIOD * DUTY) / 100;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0;
  logic cycleStart = 1'b0;
  logic rampTrip = 1'b0;
  logic ocpHiTrip = 1'b0;
  logic ocpLoTrip = 1'b0;
  logic skipReq = 1'b0;
  logic lightLoad = 1'b0;
  logic gateOn;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  boost_gate_ctrl #(
    .PERIOD_CYC   (PERIOD),
    .DUTY_PCT     (DUTY),
    .MIN_ON_CYC   (MINON),
    .SKIP_PERIODS (SKIPN)
  ) u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (enable),
    .cycleStart (cycleStart),
    .rampTrip   (rampTrip),
    .ocpHiTrip  (ocpHiTrip),
    .ocpLoTrip  (ocpLoTrip),
    .skipReq    (skipReq),
    .lightLoad  (lightLoad),
    .gateOn     (gateOn)
  );

  // vector: {light, rampAt[7:0], ocpHiAt[7:0], ocpLoAt[7:0]}; 0 = never
  localparam int NVEC = 11;
  localparam logic [24:0] VEC [NVEC] = '{
    {1'b0, 8'd0,  8'd0, 8'd0},   // R4 ceiling
    {1'b0, 8'd10, 8'd0, 8'd0},   // R2
    {1'b0, 8'd1,  8'd0, 8'd0},   // R3 blanked early trip
    {1'b0, 8'd3,  8'd0, 8'd0},   // R3 trip at end of blanking
    {1'b0, 8'd2,  8'd2, 8'd0},   // R5 priority over blanking
    {1'b0, 8'd20, 8'd5, 8'd0},   // R5
    {1'b1, 8'd20, 8'd5, 8'd0},   // R6 high flag ignored in light mode
    {1'b1, 8'd0,  8'd0, 8'd4},   // R6 low flag used in light mode
    {1'b0, 8'd15, 8'd0, 8'd4},   // R6 low flag ignored in normal mode
    {1'b0, 8'd47, 8'd0, 8'd0},   // R4 trip at ceiling
    {1'b0, 8'd48, 8'd0, 8'd0}    // R4 trip after ceiling
  };

  function automatic int expectHigh(input bit light, input int tAt, input int hAt, input int lAt);
    int e;
    int o;
    e = MAXON;
    if (tAt > 0) e = (e < ((tAt > MINON) ? tAt : MINON)) ? e : ((tAt > MINON) ? tAt : MINON);
    o = light ? lAt : hAt;
    if (o > 0 && o < e) e = o;
    return e;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // one full period starting with a cycleStart pulse
  task automatic runPeriod(input bit light, input bit skip, input int tAt, input int hAt,
                           input int lAt, output int hi, output int firstHi);
    @(negedge clk);
    lightLoad = light; skipReq = skip; cycleStart = 1'b1;
    rampTrip = 1'b0; ocpHiTrip = 1'b0; ocpLoTrip = 1'b0;
    hi = 0; firstHi = 0;
    for (int k = 1; k < PERIOD; k++) begin
      @(negedge clk);
      cycleStart = 1'b0; skipReq = 1'b0;
      if (gateOn) begin
        hi++;
        if (firstHi == 0) firstHi = k;
      end
      if (k == tAt) rampTrip = 1'b1;
      if (k == hAt) ocpHiTrip = 1'b1;
      if (k == lAt) ocpLoTrip = 1'b1;
    end
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int hi;
    int fh;
    int e;
    repeat (3) @(negedge clk);
    check(gateOn == 1'b0, "R9 gate low in reset", int'(gateOn), 0);
    rst_n = 1'b1;
    enable = 1'b1;
    repeat (3) @(negedge clk);
    check(gateOn == 1'b0, "R9 gate low after reset", int'(gateOn), 0);

    for (int v = 0; v < NVEC; v++) begin
      e = expectHigh(VEC[v][24], int'(VEC[v][23:16]), int'(VEC[v][15:8]), int'(VEC[v][7:0]));
      runPeriod(VEC[v][24], 1'b0, int'(VEC[v][23:16]), int'(VEC[v][15:8]), int'(VEC[v][7:0]), hi, fh);
      check(hi == e, $sformatf("R2/R3/R4/R5/R6 vector %0d on cycles", v), hi, e);
      check(fh == 1, $sformatf("R1 vector %0d rise after start", v), fh, 1);
    end

    // R7: skip three whole periods, then switch again
    runPeriod(1'b0, 1'b1, 0, 0, 0, hi, fh);
    check(hi == 0, "R7 skipped period 1", hi, 0);
    runPeriod(1'b0, 1'b0, 0, 0, 0, hi, fh);
    check(hi == 0, "R7 skipped period 2", hi, 0);
    runPeriod(1'b0, 1'b0, 0, 0, 0, hi, fh);
    check(hi == 0, "R7 skipped period 3", hi, 0);
    runPeriod(1'b0, 1'b0, 0, 0, 0, hi, fh);
    check(hi == MAXON, "R7 resumes after skip", hi, MAXON);

    // R8: disable mid on time
    @(negedge clk);
    cycleStart = 1'b1;
    for (int k = 1; k <= 10; k++) begin
      @(negedge clk);
      cycleStart = 1'b0;
    end
    check(gateOn == 1'b1, "R1 gate high before disable", int'(gateOn), 1);
    enable = 1'b0;
    @(negedge clk);
    check(gateOn == 1'b0, "R8 gate low one clock after disable", int'(gateOn), 0);
    cycleStart = 1'b1;
    @(negedge clk);
    cycleStart = 1'b0;
    @(negedge clk);
    check(gateOn == 1'b0, "R8 start ignored while disabled", int'(gateOn), 0);
    enable = 1'b1;

    // R8: disable clears a pending skip
    runPeriod(1'b0, 1'b1, 0, 0, 0, hi, fh);
    check(hi == 0, "R7 skip armed", hi, 0);
    @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    enable = 1'b1;
    runPeriod(1'b0, 1'b0, 0, 0, 0, hi, fh);
    check(hi == MAXON, "R8 disable cleared pending skip", hi, MAXON);

    // R1: start pulse during on time is ignored, ramp ends pulse normally
    @(negedge clk);
    cycleStart = 1'b1; rampTrip = 1'b0;
    hi = 0;
    for (int k = 1; k < PERIOD; k++) begin
      @(negedge clk);
      cycleStart = (k == 5);
      if (gateOn) hi++;
      if (k == 12) rampTrip = 1'b1;
    end
    cycleStart = 1'b0; rampTrip = 1'b0;
    check(hi == 12, "R1 start during on time ignored", hi, 12);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule